// File: doc/BRIEF.md
# ECC Memory Cycle Sequencer

This block is the back end of a dynamic-memory controller. It takes queued commands one at a time from a command file and runs each one against an external array. Every array word is 72 bits wide: a 64-bit quadword plus 8 check bits. On writes the block generates the check bits. On reads it checks them, corrects any single-bit fault and flags double-bit faults. It then returns read data and status to the bus side.

A write that sets only some bytes cannot be stored on its own, because one set of check bits covers the whole quadword. The block therefore reads the quadword and corrects it, merges in the new bytes, re-encodes the word and writes it back. A longword write is a masked write that selects four bytes. A longword read returns the whole quadword, and the caller picks the half it wants.

A programmable interval timer raises refresh requests. A pending refresh is served before the next command, but it never interrupts a command that is already running. An interlock flag lets processes synchronise through memory.

Top module: `ecc_mem_seq`

## Requirements
- R1: Array word layout is bits [63:0] data and bits [71:64] check bits, with check bit j at bit 64+j. The check bits use an odd-weight-column single-correct double-detect code. A clean read returns the stored data with no status flags set.
- R2: A read of a word with exactly one flipped bit, in any of the 72 positions, returns the corrected data with rsp_corr_o=1 and rsp_err_o=0.
- R3: A read of a word with two flipped bits returns rsp_err_o=1 and rsp_corr_o=0.
- R4: syndrome_o is 0 after reset. It captures the syndrome of the latest decode that had a non-zero syndrome, and clean reads leave it unchanged. A fault in check bit j alone gives 1<<j. A single data-bit fault gives an odd weight of at least 3. A double fault gives an even, non-zero weight.
- R5: A write with cmd_mask_i=8'hFF is done in exactly one array access (a write) and sets no flags.
- R6: A write with any other mask takes two array accesses: a read, then a write. The write holds the corrected old word, with byte b (bits 8b+7:8b) replaced wherever mask bit b is 1. rsp_corr_o reports a corrected fault in the old word. A longword write uses mask 8'h0F or 8'hF0.
- R7: A masked write to a word with a double fault is aborted after its read. It makes one access, returns rsp_err_o=1 and leaves the stored word unchanged.
- R8: With refresh_interval_i=N>0 and no commands, mem_refresh_o pulses for one cycle every N cycles. N=0 stops refresh.
- R9: A pending refresh is served before the next command is accepted. A refresh never happens in the same cycle as an array access, nor in the cycle right after one.
- R10: Commands run in acceptance order. Each command gives exactly one single-cycle rsp_valid_o pulse.
- R11: Op codes are 00 read, 01 interlock read, 10 write and 11 interlock write. An interlock read sets the interlock flag. While the flag is set, an interlock read gets rsp_busy_o=1 and makes no array access. Ordinary reads are not affected.
- R12: An interlock write clears the flag and is otherwise an ordinary write.
- R13: During and right after reset, rsp_valid_o, mem_req_o and mem_refresh_o are 0 and cmd_ready_o is 1 (refresh interval 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command file has a command |
| cmd_ready_o | output | 1 | Command is taken on this edge |
| cmd_op_i | input | 2 | Operation code (R11) |
| cmd_addr_i | input | ADDR_W | Quadword address |
| cmd_mask_i | input | 8 | Byte enables for writes |
| cmd_wdata_i | input | 64 | Write data |
| refresh_interval_i | input | TIMER_W | Refresh period in cycles, 0 disables |
| mem_req_o | output | 1 | Array access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | ADDR_W | Array address |
| mem_wdata_o | output | 72 | Encoded word to store |
| mem_rdata_i | input | 72 | Word read, valid the cycle after a read access |
| mem_refresh_o | output | 1 | Refresh cycle |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_busy_o | output | 1 | Interlock busy answer |
| rsp_corr_o | output | 1 | Single-bit fault corrected |
| rsp_err_o | output | 1 | Uncorrectable fault |
| rsp_data_o | output | 64 | Read data |
| syndrome_o | output | 8 | Syndrome of the latest faulty decode |

## Verification
A wrong interlock flag shows up at the next interlock read, either as a busy answer that should not appear or as a missing one, together with a change in the array access count. A wrong merge or wrong check-bit generation stays hidden until the word is read back. At that point it appears as wrong data or as a false corrected flag, so every masked write is followed by a read. A stuck refresh timer or pending flag shows within one refresh interval, as a wrong pulse count in an idle window or as a refresh that sits next to an array access.

// File: rtl/ecc_seq_pkg.sv
package ecc_seq_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int WORD_W = DATA_W + CHK_W;
  localparam int BYTES  = DATA_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REFRESH, ST_RD_ISSUE, ST_DECODE, ST_WRITE
  } seq_st_e;

  // column idx of the H matrix: weight-3 codes first, then weight-5
  function automatic logic [CHK_W-1:0] col_code(input int idx);
    int n;
    logic [CHK_W-1:0] res;
    n   = 0;
    res = '0;
    for (int w = 3; w <= 5; w += 2) begin
      for (int v = 0; v < 256; v++) begin
        if ($countones(v[7:0]) == w) begin
          if (n == idx) res = v[7:0];
          n++;
        end
      end
    end
    return res;
  endfunction

  function automatic logic [DATA_W-1:0] row_mask(input int j);
    logic [DATA_W-1:0] m;
    logic [CHK_W-1:0]  c;
    for (int i = 0; i < DATA_W; i++) begin
      c    = col_code(i);
      m[i] = c[j];
    end
    return m;
  endfunction
endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
  import ecc_seq_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);
  for (genvar j = 0; j < CHK_W; j++) begin : g_chk
    localparam logic [DATA_W-1:0] ROW = row_mask(j);
    assign chk_o[j] = ^(data_i & ROW);
  end
endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
  import ecc_seq_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CHK_W-1:0]  syn_o,
  output logic              corr_o,
  output logic              uncorr_o
);
  logic [CHK_W-1:0]  calc;
  logic [DATA_W-1:0] hit;
  logic              chk_hit;

  ecc_enc u_enc (.data_i(word_i[DATA_W-1:0]), .chk_o(calc));

  assign syn_o = word_i[WORD_W-1:DATA_W] ^ calc;

  for (genvar i = 0; i < DATA_W; i++) begin : g_col
    localparam logic [CHK_W-1:0] COL = col_code(i);
    assign hit[i] = (syn_o == COL);
  end

  assign chk_hit  = ($countones(syn_o) == 1);
  assign data_o   = word_i[DATA_W-1:0] ^ hit;
  assign corr_o   = (|hit) | chk_hit;
  assign uncorr_o = (syn_o != '0) & ~corr_o;
endmodule

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] interval_i,
  input  logic             grant_i,
  output logic             pend_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign tick = (interval_i != '0) && (cnt_q >= interval_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_o <= 1'b0;
    end else begin
      if (interval_i == '0 || tick) cnt_q <= '0;
      else                          cnt_q <= cnt_q + CNT_W'(1);
      pend_o <= tick | (pend_o & ~grant_i);
    end
  end

  // R8
  pend_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_o) |-> $past(interval_i) != '0);
endmodule

// File: rtl/ecc_mem_seq.sv
module ecc_mem_seq
  import ecc_seq_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int TIMER_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  output logic                cmd_ready_o,
  input  logic [1:0]          cmd_op_i,
  input  logic [ADDR_W-1:0]   cmd_addr_i,
  input  logic [BYTES-1:0]    cmd_mask_i,
  input  logic [DATA_W-1:0]   cmd_wdata_i,
  input  logic [TIMER_W-1:0]  refresh_interval_i,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [WORD_W-1:0]   mem_wdata_o,
  input  logic [WORD_W-1:0]   mem_rdata_i,
  output logic                mem_refresh_o,
  output logic                rsp_valid_o,
  output logic                rsp_busy_o,
  output logic                rsp_corr_o,
  output logic                rsp_err_o,
  output logic [DATA_W-1:0]   rsp_data_o,
  output logic [CHK_W-1:0]    syndrome_o
);
  seq_st_e            st_q;
  logic               op_wr_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [BYTES-1:0]   mask_q;
  logic [DATA_W-1:0]  wdata_q, wbuf_q, merged;
  logic               corr_q, lock_q;
  logic               ref_pend, ref_grant;
  logic [CHK_W-1:0]   wchk;
  logic [DATA_W-1:0]  dec_data;
  logic [CHK_W-1:0]   dec_syn;
  logic               dec_corr, dec_uncorr;
  logic               cmd_rd, cmd_lock, lock_busy;

  refresh_timer #(.CNT_W(TIMER_W)) u_ref (
    .clk_i(clk_i), .rst_ni(rst_ni), .interval_i(refresh_interval_i),
    .grant_i(ref_grant), .pend_o(ref_pend)
  );

  ecc_dec u_dec (
    .word_i(mem_rdata_i), .data_o(dec_data), .syn_o(dec_syn),
    .corr_o(dec_corr), .uncorr_o(dec_uncorr)
  );

  ecc_enc u_enc (.data_i(wbuf_q), .chk_o(wchk));

  // byte merge of corrected old word with new bytes
  for (genvar b = 0; b < BYTES; b++) begin : g_merge
    assign merged[8*b +: 8] = mask_q[b] ? wdata_q[8*b +: 8] : dec_data[8*b +: 8];
  end

  assign cmd_ready_o   = (st_q == ST_IDLE) & ~ref_pend;
  assign ref_grant     = (st_q == ST_IDLE) & ref_pend;
  assign cmd_rd        = ~cmd_op_i[1];
  assign cmd_lock      = cmd_op_i[0];
  assign lock_busy     = cmd_rd & cmd_lock & lock_q;

  assign mem_req_o     = (st_q == ST_RD_ISSUE) | (st_q == ST_WRITE);
  assign mem_we_o      = (st_q == ST_WRITE);
  assign mem_addr_o    = addr_q;
  assign mem_wdata_o   = {wchk, wbuf_q};
  assign mem_refresh_o = (st_q == ST_REFRESH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      op_wr_q     <= 1'b0;
      addr_q      <= '0;
      mask_q      <= '0;
      wdata_q     <= '0;
      wbuf_q      <= '0;
      corr_q      <= 1'b0;
      lock_q      <= 1'b0;
      rsp_valid_o <= 1'b0;
      rsp_busy_o  <= 1'b0;
      rsp_corr_o  <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_data_o  <= '0;
      syndrome_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (ref_pend) begin
            st_q <= ST_REFRESH;
          end else if (cmd_valid_i) begin
            op_wr_q <= ~cmd_rd;
            addr_q  <= cmd_addr_i;
            mask_q  <= cmd_mask_i;
            wdata_q <= cmd_wdata_i;
            if (lock_busy) begin
              rsp_valid_o <= 1'b1;
              rsp_busy_o  <= 1'b1;
              rsp_corr_o  <= 1'b0;
              rsp_err_o   <= 1'b0;
              rsp_data_o  <= '0;
            end else if (cmd_rd) begin
              if (cmd_lock) lock_q <= 1'b1;
              st_q <= ST_RD_ISSUE;
            end else begin
              if (cmd_lock) lock_q <= 1'b0;
              if (&cmd_mask_i) begin
                wbuf_q <= cmd_wdata_i;
                corr_q <= 1'b0;
                st_q   <= ST_WRITE;
              end else begin
                st_q <= ST_RD_ISSUE;
              end
            end
          end
        end
        ST_REFRESH:  st_q <= ST_IDLE;
        ST_RD_ISSUE: st_q <= ST_DECODE;
        ST_DECODE: begin
          if (dec_syn != '0) syndrome_o <= dec_syn;
          if (!op_wr_q || dec_uncorr) begin
            rsp_valid_o <= 1'b1;
            rsp_busy_o  <= 1'b0;
            rsp_corr_o  <= dec_corr;
            rsp_err_o   <= dec_uncorr;
            rsp_data_o  <= op_wr_q ? '0 : dec_data;
            st_q        <= ST_IDLE;
          end else begin
            wbuf_q <= merged;
            corr_q <= dec_corr;
            st_q   <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          rsp_valid_o <= 1'b1;
          rsp_busy_o  <= 1'b0;
          rsp_corr_o  <= corr_q;
          rsp_err_o   <= 1'b0;
          rsp_data_o  <= '0;
          st_q        <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R9
  ref_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_pend && st_q == ST_IDLE) |=> mem_refresh_o);
  // R9
  ref_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_refresh_o |-> !$past(mem_req_o));
  // R6
  rmw_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mask_q != '1) |-> $past(st_q) == ST_DECODE);
  // R7
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DECODE && op_wr_q && dec_uncorr) |=> !mem_req_o);
  // R4
  syn_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_DECODE) |=> $stable(syndrome_o));
  // R11
  busy_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_busy_o) |-> !$past(mem_req_o));
endmodule

// File: tb/ecc_mem_seq_tb_top.sv
`timescale 1ns/1ps
module ecc_mem_seq_tb_top;
  localparam int AW = 6;
  localparam logic [1:0] OP_RD = 2'b00, OP_RDL = 2'b01, OP_WR = 2'b10, OP_WRL = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0] cmd_mask = '0;
  logic [63:0] cmd_wdata = '0;
  logic [15:0] interval = '0;
  logic mem_req, mem_we, mem_refresh;
  logic [AW-1:0] mem_addr;
  logic [71:0] mem_wdata, mem_rdata;
  logic rsp_valid, rsp_busy, rsp_corr, rsp_err;
  logic [63:0] rsp_data;
  logic [7:0] syn;

  always #4 clk = ~clk;

  ecc_mem_seq #(.ADDR_W(AW), .TIMER_W(16)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_addr_i(cmd_addr), .cmd_mask_i(cmd_mask), .cmd_wdata_i(cmd_wdata),
    .refresh_interval_i(interval), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_refresh_o(mem_refresh), .rsp_valid_o(rsp_valid), .rsp_busy_o(rsp_busy),
    .rsp_corr_o(rsp_corr), .rsp_err_o(rsp_err), .rsp_data_o(rsp_data), .syndrome_o(syn)
  );

  // array model with fault injection port
  logic [71:0] arr [64];
  logic inj_en = 1'b0;
  logic [AW-1:0] inj_addr = '0;
  logic [71:0] inj_mask = '0;
  int n_chk = 0, n_bad = 0;
  int acc_cnt = 0, ref_cnt = 0, rsp_seen = 0, issued = 0;
  bit prev_req = 1'b0, done = 1'b0;

  always @(posedge clk) begin
    if (inj_en) arr[inj_addr] <= arr[inj_addr] ^ inj_mask;
    if (mem_req) begin
      if (mem_we) arr[mem_addr] <= mem_wdata;
      else        mem_rdata <= arr[mem_addr];
    end
  end

  // per-clock observation
  always @(posedge clk) begin
    if (mem_req) acc_cnt++;
    if (rsp_valid) rsp_seen++;
    if (mem_refresh) begin
      ref_cnt++;
      n_chk++;
      if (mem_req || prev_req) begin
        n_bad++;
        $display("FAIL R9 refresh next to access act=%0d exp=0", mem_req | prev_req);
      end
    end
    prev_req <= mem_req;
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  logic [63:0] m_data [64];
  int m_flips [64];
  bit m_lock = 1'b0;

  task automatic do_cmd(input logic [1:0] op, input int a, input logic [7:0] mask,
                        input logic [63:0] wd, input string req);
    bit e_busy = 0, e_corr = 0, e_err = 0, c_data = 0;
    logic [63:0] e_data = '0;
    int e_acc = 0, a0;
    bit rd = !op[1], lk = op[0];
    if (rd) begin
      if (lk && m_lock) begin
        e_busy = 1;
      end else begin
        if (lk) m_lock = 1;
        e_acc = 1;
        if (m_flips[a] >= 2) e_err = 1;
        else begin e_data = m_data[a]; c_data = 1; e_corr = (m_flips[a] == 1); end
      end
    end else begin
      if (lk) m_lock = 0;
      if (mask == 8'hFF) begin
        e_acc = 1; m_data[a] = wd; m_flips[a] = 0;
      end else if (m_flips[a] >= 2) begin
        e_acc = 1; e_err = 1;
      end else begin
        e_acc = 2; e_corr = (m_flips[a] == 1);
        for (int b = 0; b < 8; b++) if (mask[b]) m_data[a][8*b +: 8] = wd[8*b +: 8];
        m_flips[a] = 0;
      end
    end
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = AW'(a); cmd_mask = mask; cmd_wdata = wd;
    while (!cmd_ready) @(negedge clk);
    a0 = acc_cnt;
    @(negedge clk);
    cmd_valid = 0;
    issued++;
    while (!rsp_valid) @(negedge clk);
    chk(req, "busy", 64'(rsp_busy), 64'(e_busy));
    chk(req, "corr", 64'(rsp_corr), 64'(e_corr));
    chk(req, "err", 64'(rsp_err), 64'(e_err));
    if (c_data) chk(req, "data", rsp_data, e_data);
    chk(req, "accesses", 64'(acc_cnt - a0), 64'(e_acc));
    @(negedge clk);
    // R10 one response per command
    chk("R10", "responses", 64'(rsp_seen), 64'(issued));
  endtask

  task automatic inject(input int a, input logic [71:0] m);
    @(negedge clk);
    inj_en = 1; inj_addr = AW'(a); inj_mask = m;
    @(negedge clk);
    inj_en = 0;
    m_flips[a] += $countones(m);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin m_flips[i] = 0; m_data[i] = '0; end
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13", "rsp_valid in reset", 64'(rsp_valid), 0);
    chk("R13", "mem_req in reset", 64'(mem_req), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R13", "ready", 64'(cmd_ready), 1);
    chk("R13", "refresh", 64'(mem_refresh), 0);
    chk("R4", "syndrome reset", 64'(syn), 0);

    // R5 full writes, R1 clean readback
    for (int a = 0; a < 8; a++)
      do_cmd(OP_WR, a, 8'hFF, 64'h0123_4567_89AB_CDEF ^ (64'(a) * 64'h1111_0000_2222_0101), "R5");
    for (int a = 0; a < 8; a++) do_cmd(OP_RD, a, 8'h00, '0, "R1");

    // R6 masked writes: longword halves and a sparse mask
    do_cmd(OP_WR, 1, 8'h0F, 64'hAAAA_BBBB_CCCC_DDDD, "R6");
    do_cmd(OP_WR, 2, 8'hF0, 64'h1234_5678_9ABC_DEF0, "R6");
    do_cmd(OP_WR, 3, 8'h5A, 64'hFEDC_BA98_7654_3210, "R6");
    for (int a = 1; a < 4; a++) do_cmd(OP_RD, a, 8'h00, '0, "R6");

    // R2 single faults, R4 syndrome values
    inject(0, 72'(1) << 5);
    do_cmd(OP_RD, 0, 8'h00, '0, "R2");
    n_chk++;
    if ($countones(syn) < 3 || $countones(syn) % 2 == 0) begin
      n_bad++; $display("FAIL R4 data-bit syndrome act=%h exp=odd weight>=3", syn);
    end
    inject(4, 72'(1) << 67);
    do_cmd(OP_RD, 4, 8'h00, '0, "R2");
    chk("R4", "check bit 3 syndrome", 64'(syn), 64'h08);
    inject(5, 72'(1) << 71);
    do_cmd(OP_RD, 5, 8'h00, '0, "R2");
    chk("R4", "check bit 7 syndrome", 64'(syn), 64'h80);
    do_cmd(OP_RD, 6, 8'h00, '0, "R1");
    chk("R4", "syndrome held on clean read", 64'(syn), 64'h80);

    // R6 masked write over a corrected fault scrubs the word
    do_cmd(OP_WR, 0, 8'h3C, 64'h5555_6666_7777_8888, "R6");
    do_cmd(OP_RD, 0, 8'h00, '0, "R6");

    // R3 double fault, R7 aborted masked write
    inject(7, (72'(1) << 10) | (72'(1) << 40));
    do_cmd(OP_RD, 7, 8'h00, '0, "R3");
    n_chk++;
    if (syn == 0 || $countones(syn) % 2 != 0) begin
      n_bad++; $display("FAIL R4 double syndrome act=%h exp=even nonzero", syn);
    end
    do_cmd(OP_WR, 7, 8'h01, 64'hFFFF_FFFF_FFFF_FFFF, "R7");
    do_cmd(OP_RD, 7, 8'h00, '0, "R7");
    do_cmd(OP_WR, 7, 8'hFF, 64'hDEAD_BEEF_0000_FFFF, "R5");
    do_cmd(OP_RD, 7, 8'h00, '0, "R1");

    // R11 / R12 interlock
    do_cmd(OP_RDL, 1, 8'h00, '0, "R11");
    do_cmd(OP_RDL, 2, 8'h00, '0, "R11");
    do_cmd(OP_RD, 2, 8'h00, '0, "R11");
    do_cmd(OP_WRL, 2, 8'hFF, 64'h0F0F_0F0F_F0F0_F0F0, "R12");
    do_cmd(OP_RDL, 2, 8'h00, '0, "R12");
    do_cmd(OP_WRL, 2, 8'hF0, 64'h1111_2222_3333_4444, "R12");
    do_cmd(OP_RDL, 3, 8'h00, '0, "R12");
    do_cmd(OP_WRL, 3, 8'hFF, 64'h0000_0000_0000_0001, "R12");

    // R8 refresh cadence while idle
    begin
      int r0;
      @(negedge clk);
      interval = 16'd20;
      while (!mem_refresh) @(negedge clk);
      r0 = ref_cnt;
      repeat (200) @(posedge clk);
      @(negedge clk);
      chk("R8", "refresh pulses in 200 cycles", 64'(ref_cnt - r0), 64'd10);
      interval = 16'd0;
      repeat (30) @(posedge clk);
      @(negedge clk);
      r0 = ref_cnt;
      repeat (100) @(posedge clk);
      @(negedge clk);
      chk("R8", "refresh stopped", 64'(ref_cnt - r0), 64'd0);
    end

    // R9 refresh mixed with traffic
    begin
      int r0;
      interval = 16'd7;
      r0 = ref_cnt;
      for (int k = 0; k < 20; k++) do_cmd(OP_RD, k % 8, 8'h00, '0, "R9");
      for (int k = 0; k < 4; k++) do_cmd(OP_WR, k, 8'h0F, 64'(k) * 64'h0101_0101_0101_0101, "R9");
      for (int k = 0; k < 4; k++) do_cmd(OP_RD, k, 8'h00, '0, "R9");
      n_chk++;
      if (ref_cnt == r0) begin
        n_bad++; $display("FAIL R9 refresh under traffic act=%0d exp=>0", ref_cnt - r0);
      end
      interval = 16'd0;
    end

    repeat (5) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule